// File: doc/BRIEF.md
# SIMD Signed Rounding Average Unit

This block is a single-cycle vector datapath. It splits two 128-bit operands into equal signed lanes and writes, for each pair of lanes, the average rounded toward plus infinity. A 4-bit size code selects the lane width: 8, 16, 32 or 64 bits. A request is a one-cycle pulse on `req_valid`, with the operands and the size code presented alongside it. One clock later the result register holds the new vector and `done` pulses. A size code outside the legal range computes nothing: the result register keeps its old contents, and `spec_err` is raised together with `done`.

Control is a three-state machine. `ST_IDLE` means no answer is pending. `ST_OK` means a legal request was taken on the last edge. `ST_BAD` means an illegal request was taken on the last edge. From any state, a request with a legal code goes to `ST_OK`, a request with an illegal code goes to `ST_BAD`, and no request goes to `ST_IDLE`. Reset forces `ST_IDLE`. `done` is decoded from "state is not `ST_IDLE`", and `spec_err` is decoded from "state is `ST_BAD`".

Top module: `simd_avg_unit`

## Requirements
- R1: Size code 0 selects sixteen 8-bit lanes, 1 selects eight 16-bit lanes, 2 selects four 32-bit lanes and 3 selects two 64-bit lanes. Lane k of width W occupies bits [127-k*W : 128-(k+1)*W], so lane 0 is at the most significant end.
- R2: Every lane is read as a signed two's-complement value. The lane result is floor((a+b+1)/2), so an exact half rounds upward: (-1,0) gives 0 and (0,1) gives 1.
- R3: No intermediate overflow occurs at any width. (max,max) gives max, (min,min) gives min and (min,max) gives 0.
- R4: Lanes are independent. No carry or sign information crosses a lane boundary at any size code.
- R5: A size code from 4 to 15 leaves the result register unchanged, and `spec_err` is high in the cycle `done` is high.
- R6: `done` is high in exactly the cycle after a request is sampled, and low in every other cycle. The new result is visible in that same cycle.
- R7: A synchronous active-high reset clears the result register, `done` and `spec_err`.
- R8: `spec_err` is high only together with `done`. A legal request that follows an illegal one leaves `spec_err` low.
- R9: Requests on consecutive cycles each produce their own `done` cycle and result, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, one cycle per request |
| size_code | input | 4 | Lane size selector (0..3 legal) |
| opa | input | 128 | First operand vector |
| opb | input | 128 | Second operand vector |
| res | output | 128 | Registered result vector |
| done | output | 1 | One-cycle completion pulse |
| spec_err | output | 1 | Illegal size code flag, valid with done |

## Verification
The hardest case to reach from the ports is a pair whose true sum needs one more bit than the lane holds, at every width at once, while neighbouring lanes hold values that would corrupt each other if a carry or sign leaked across a boundary. The bench builds vectors in which every lane holds the same extreme pair, and vectors in which max and min lanes alternate. It also sweeps all 65,536 pairs of 8-bit values, sixteen pairs per request. Every result is compared against two independently written bench models: a widened sum, and a shift-and-carry form.

// File: rtl/avg_pkg.sv
package avg_pkg;

    localparam int NUM_SIZES = 4;
    localparam int SEL_W     = $clog2(NUM_SIZES);
    localparam int BASE_W    = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OK   = 2'd1,
        ST_BAD  = 2'd2
    } avg_state_e;

    function automatic int lane_width(input int k);
        return BASE_W << k;
    endfunction

endpackage

// File: rtl/avg_lane.sv
module avg_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    logic [W-1:0] half_a;
    logic [W-1:0] half_b;
    logic [W-1:0] round_bit;

    // Halve each operand with sign fill, then restore the two dropped
    // half-units and the rounding half as a single carry into bit 0.
    always_comb begin
        half_a    = {a[W-1], a[W-1:1]};
        half_b    = {b[W-1], b[W-1:1]};
        round_bit = {{(W-1){1'b0}}, a[0] | b[0]};
        y         = half_a + half_b + round_bit;
    end
endmodule

// File: rtl/avg_lane_bank.sv
module avg_lane_bank #(
    parameter int VEC_W  = 128,
    parameter int LANE_W = 8
) (
    input  logic [VEC_W-1:0] va,
    input  logic [VEC_W-1:0] vb,
    output logic [VEC_W-1:0] vy
);
    localparam int LANES = VEC_W / LANE_W;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam int HI = VEC_W - 1 - k * LANE_W;
        avg_lane #(.W(LANE_W)) u_lane (
            .a (va[HI -: LANE_W]),
            .b (vb[HI -: LANE_W]),
            .y (vy[HI -: LANE_W])
        );
    end
endmodule

// File: rtl/avg_result_mux.sv
module avg_result_mux #(
    parameter int VEC_W = 128,
    parameter int NSEL  = 4,
    parameter int SEL_W = 2
) (
    input  logic [NSEL-1:0][VEC_W-1:0] cand,
    input  logic [SEL_W-1:0]           sel,
    output logic [VEC_W-1:0]           pick
);
    always_comb begin
        pick = cand[0];
        for (int i = 1; i < NSEL; i++) begin
            if (sel == SEL_W'(i)) pick = cand[i];
        end
    end
endmodule

// File: rtl/simd_avg_unit.sv
module simd_avg_unit
    import avg_pkg::*;
#(
    parameter int VEC_W  = 128,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [CODE_W-1:0] size_code,
    input  logic [VEC_W-1:0]  opa,
    input  logic [VEC_W-1:0]  opb,
    output logic [VEC_W-1:0]  res,
    output logic              done,
    output logic              spec_err
);
    logic [NUM_SIZES-1:0][VEC_W-1:0] cand;
    logic [VEC_W-1:0]                picked;
    logic                            code_legal;
    avg_state_e                      state_q;
    avg_state_e                      state_d;

    assign code_legal = (size_code < CODE_W'(NUM_SIZES));

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_width
        avg_lane_bank #(.VEC_W(VEC_W), .LANE_W(lane_width(s))) u_bank (
            .va (opa),
            .vb (opb),
            .vy (cand[s])
        );
    end

    avg_result_mux #(.VEC_W(VEC_W), .NSEL(NUM_SIZES), .SEL_W(SEL_W)) u_mux (
        .cand (cand),
        .sel  (size_code[SEL_W-1:0]),
        .pick (picked)
    );

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_OK, ST_BAD: begin
                if (req_valid) state_d = code_legal ? ST_OK : ST_BAD;
                else           state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)                          res <= '0;
        else if (req_valid && code_legal) res <= picked;
    end

    always_comb begin
        done     = 1'b0;
        spec_err = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_OK:   done = 1'b1;
            ST_BAD: begin
                done     = 1'b1;
                spec_err = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/simd_avg_unit_chk.sv
module simd_avg_unit_chk #(
    parameter int VEC_W  = 128,
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [CODE_W-1:0] size_code,
    input logic [VEC_W-1:0]  opa,
    input logic [VEC_W-1:0]  opb,
    input logic [VEC_W-1:0]  res,
    input logic              done,
    input logic              spec_err
);
    logic [7:0] top_a;
    logic [7:0] top_b;
    logic [8:0] wide_sum;
    logic       last_code0;

    always_ff @(posedge clk) begin
        if (rst) begin
            top_a      <= '0;
            top_b      <= '0;
            last_code0 <= 1'b0;
        end else begin
            top_a      <= opa[VEC_W-1 -: 8];
            top_b      <= opb[VEC_W-1 -: 8];
            last_code0 <= req_valid && (size_code == '0);
        end
    end

    assign wide_sum = {top_a[7], top_a} + {top_b[7], top_b} + 9'd1;

    // R6: done only follows a sampled request
    assert_done_follows_req_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(req_valid));

    // R6: done lasts a single cycle unless a fresh request arrives
    assert_done_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        (done && !req_valid) |=> !done);

    // R8: error flag never without done
    assert_err_with_done_R8: assert property (@(posedge clk) disable iff (rst)
        spec_err |-> done);

    // R5: illegal request leaves the result untouched
    assert_err_keeps_res_R5: assert property (@(posedge clk) disable iff (rst)
        spec_err |-> $stable(res));

    // R5: a flagged answer came from an out-of-range code, a clean one from a legal code
    assert_err_matches_code_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> (spec_err == ($past(size_code) >= CODE_W'(4))));

    // R7: first cycle after reset shows cleared outputs
    assert_reset_clears_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (res == '0 && !done && !spec_err));

    // R2: most significant 8-bit lane equals the widened rounded sum
    assert_lane0_avg_R2: assert property (@(posedge clk) disable iff (rst)
        (done && last_code0) |->
            (({res[VEC_W-1 -: 8], 1'b0} | {8'b0, wide_sum[0]}) == wide_sum));
endmodule

bind simd_avg_unit simd_avg_unit_chk #(.VEC_W(VEC_W), .CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .size_code (size_code),
    .opa       (opa),
    .opb       (opb),
    .res       (res),
    .done      (done),
    .spec_err  (spec_err)
);

// File: tb/test_simd_avg_unit.sv
`timescale 1ns/1ps
module test_simd_avg_unit;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic [3:0]   size_code = '0;
    logic [127:0] opa = '0;
    logic [127:0] opb = '0;
    logic [127:0] res;
    logic         done;
    logic         spec_err;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;
    logic [127:0] last_res = '0;
    logic [63:0]  lfsr = 64'h9e37_79b9_7f4a_7c15;

    always #5 clk = ~clk;

    simd_avg_unit i_simd_avg_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .size_code(size_code),
        .opa(opa), .opb(opb), .res(res), .done(done), .spec_err(spec_err)
    );

    function automatic logic [127:0] lane_mask(input int w);
        return (w == 128) ? '1 : ((128'd1 << w) - 128'd1);
    endfunction

    function automatic logic signed [65:0] sext(input logic [127:0] v, input int w);
        logic [65:0] x;
        x = v[65:0] & lane_mask(w)[65:0];
        if (v[w-1]) x = x | ~((66'd1 << w) - 66'd1);
        return $signed(x);
    endfunction

    // form 0: widened sum then halve; form 1: halve each then carry in
    function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                           input int w, input bit form);
        logic [127:0] out;
        logic [127:0] m;
        out = '0;
        m = lane_mask(w);
        for (int i = 0; i < 128 / w; i++) begin
            int sh;
            logic signed [65:0] sa, sb, r;
            logic [127:0] la, lb;
            sh = 128 - (i + 1) * w;
            la = (a >> sh) & m;
            lb = (b >> sh) & m;
            sa = sext(la, w);
            sb = sext(lb, w);
            if (!form) r = (sa + sb + 66'sd1) >>> 1;
            else       r = (sa >>> 1) + (sb >>> 1) + 66'sd0 + {65'd0, la[0] | lb[0]};
            out = out | ((128'(r) & m) << sh);
        end
        return out;
    endfunction

    function automatic logic [127:0] splat(input logic [127:0] v, input int w);
        logic [127:0] out;
        out = '0;
        for (int i = 0; i < 128 / w; i++) out = out | ((v & lane_mask(w)) << (i * w));
        return out;
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
    endtask

    task automatic run(input int code, input logic [127:0] a, input logic [127:0] b,
                       input string req);
        logic [127:0] ea, eb;
        @(negedge clk);
        req_valid = 1'b1; size_code = 4'(code); opa = a; opb = b;
        @(negedge clk);
        req_valid = 1'b0;
        if (code < 4) begin
            ea = model(a, b, 8 << code, 1'b0);
            eb = model(a, b, 8 << code, 1'b1);
            check(ea == eb, {req, " models"}, ea, eb);
            check(done && !spec_err && res == ea, req, res, ea);
            last_res = ea;
        end else begin
            check(done && spec_err && res == last_res, req, res, last_res);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state
        check(res == '0 && !done && !spec_err, "R7 reset", res, '0);
        rst = 1'b0;
        @(negedge clk);
        check(!done && !spec_err, "R6 idle", {126'd0, done, spec_err}, '0);

        // R2 R3: exhaustive 8-bit pair sweep, sixteen pairs per request
        for (int x = 0; x < 256; x++) begin
            for (int g = 0; g < 16; g++) begin
                logic [127:0] va, vb;
                va = '0; vb = '0;
                for (int k = 0; k < 16; k++) begin
                    va = (va << 8) | 128'(x);
                    vb = (vb << 8) | 128'(g * 16 + k);
                end
                run(0, va, vb, "R2 sweep8");
            end
        end

        // R1 R3: corner pairs at every width
        for (int c = 0; c < 4; c++) begin
            int w;
            logic [127:0] mx, mn, m1;
            w = 8 << c;
            mx = (128'd1 << (w - 1)) - 128'd1;
            mn = 128'd1 << (w - 1);
            m1 = lane_mask(w);
            run(c, splat(mx, w), splat(mx, w), "R3 max,max");
            run(c, splat(mn, w), splat(mn, w), "R3 min,min");
            run(c, splat(mn, w), splat(mx, w), "R3 min,max");
            run(c, splat(mx, w), splat(mn, w), "R3 max,min");
            run(c, splat(m1, w), splat(0, w), "R2 -1,0");
            run(c, splat(0, w), splat(1, w), "R2 0,1");
            // R4: alternating extremes so any leak between lanes shows
            run(c, splat((mx << w) | mn, 2 * w), splat((mx << w) | mx, 2 * w), "R4 alt");
            run(c, splat((m1 << w) | m1, 2 * w), splat((128'd1 << w) | 128'd1, 2 * w), "R4 carry");
        end

        // R1 R4: pseudo-random vectors at every width
        for (int c = 0; c < 4; c++) begin
            for (int n = 0; n < 150; n++) begin
                logic [127:0] va, vb;
                step_lfsr(); va[127:64] = lfsr;
                step_lfsr(); va[63:0]   = lfsr;
                step_lfsr(); vb[127:64] = lfsr;
                step_lfsr(); vb[63:0]   = lfsr;
                run(c, va, vb, "R1 random");
            end
        end

        // R1: lane 0 at most significant end, 16-bit lanes
        run(1, {16'h0004, 112'd0}, {16'h0002, 112'd0}, "R1 lane order");
        check(res[127:112] == 16'h0003 && res[111:0] == '0, "R1 lane0 msb", res,
              {16'h0003, 112'd0});

        // R5: every illegal code leaves result, raises flag
        for (int c = 4; c < 16; c++) run(c, '1, '1, "R5 illegal");
        // R8: legal after illegal clears flag
        run(2, splat(128'd7, 32), splat(128'd8, 32), "R8 legal after bad");
        check(!spec_err, "R8 flag clear", {127'd0, spec_err}, '0);

        // R6: done lasts one cycle
        @(negedge clk);
        check(!done && !spec_err, "R6 single pulse", {126'd0, done, spec_err}, '0);

        // R9: back-to-back requests
        @(negedge clk);
        req_valid = 1'b1; size_code = 4'd0; opa = splat(128'h10, 8); opb = splat(128'h20, 8);
        @(negedge clk);
        check(done && res == splat(128'h18, 8), "R9 first", res, splat(128'h18, 8));
        size_code = 4'd9; opa = '0; opb = '0;
        @(negedge clk);
        check(done && spec_err && res == splat(128'h18, 8), "R9 second", res, splat(128'h18, 8));
        size_code = 4'd3; opa = splat(128'h5, 64); opb = splat(128'h8, 64);
        @(negedge clk);
        req_valid = 1'b0;
        check(done && !spec_err && res == splat(128'h7, 64), "R9 third", res, splat(128'h7, 64));
        @(negedge clk);
        check(!done, "R9 end", {127'd0, done}, '0);

        // R7: reset mid-run clears result
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(res == '0 && !done && !spec_err, "R7 mid reset", res, '0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule